// File: doc/BRIEF.md
# Nested Interrupt Acknowledge Controller

This block decides, at each instruction boundary of a small processor core, whether a waiting interrupt is taken. It watches three kinds of source: a software break presented by the decoder, one non-maskable request, and a parameterised set of maskable requests. Each maskable line carries a one-bit programmable level, where 0 is the high level and 1 is the low level. The block owns the global enable flag, the single in-service level flag and a flag marking non-maskable service in progress. It keeps maskable and non-maskable requests latched until they are taken.

When it takes a source, the block raises an acknowledge pulse carrying the source kind, the line index and the vector address. It then sequences two pushes: the flag word first and the program counter second. The flag values it reports for the push are those held before entry. The decoder reports the two return kinds (normal return and break return) as strobes, along with the flag bits popped from the stack, and the block restores its state from them. Stack memory, decode and the datapath lie outside the block.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the enable flag is 0, the in-service level flag is 1, the non-maskable busy flag is 0, and the acknowledge, push strobes and latched requests are all clear.
- R2: A break request presented with the boundary input high is always taken at that boundary, whatever the enable flag and busy flag hold. It reports kind code 3 and vector 0x003E.
- R3: Taking any source gives, one cycle after the boundary edge, ack together with the flag-word push strobe. At the same time the enable flag reads 0 and the saved enable and level outputs show the values from before entry. The program-counter push strobe follows in the next cycle.
- R4: A maskable request is taken only while the enable flag is 1. Otherwise it stays latched.
- R5: With the enable flag at 1, a maskable request of level 0 is eligible whatever the in-service flag holds. A request of level 1 is eligible only when the in-service flag is 1. Taking a maskable request loads the in-service flag with that request's level.
- R6: Among eligible maskable requests, any of level 0 beats any of level 1, and a tie goes to the lowest index. The ack reports kind code 2 and the index.
- R7: While the busy flag is set, no maskable or non-maskable request is taken. A non-maskable request is taken regardless of the enable flag, with kind code 1 and vector 0x0002, and it sets the busy flag. A break beats a non-maskable request at the same boundary, and a non-maskable request beats a maskable one.
- R8: A normal-return or break-return strobe loads the enable and level flags from the popped bits. Only the normal return clears the busy flag.
- R9: After any return, the next boundary takes no maskable request. A request held back is taken at the boundary after that.
- R10: Request lines and the break line are sampled only while the boundary input is high. A pulse at any other time has no effect. Requests that are refused stay latched, and the taken request's latch is cleared.
- R11: The enable and disable strobes set and clear the enable flag. All enable, disable and return strobes are ignored in a cycle where the boundary input is high.
- R12: A maskable request with index i reports vector 0x0004 + 2*i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_bnd | input | 1 | Instruction boundary; requests are sampled here |
| brk_req | input | 1 | Software break presented by decode |
| nmi_req | input | 1 | Non-maskable request |
| irq_req | input | N_SRC | Maskable request lines |
| irq_lo | input | N_SRC | Programmable level per line, 1 = low |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| reti_stb | input | 1 | Normal return strobe |
| retb_stb | input | 1 | Break return strobe |
| pop_ie | input | 1 | Enable bit popped on return |
| pop_isp | input | 1 | Level bit popped on return |
| ack | output | 1 | One-cycle acknowledge |
| ack_kind | output | 2 | 1 non-maskable, 2 maskable, 3 break |
| ack_idx | output | IDX_W | Index of the taken maskable line |
| vec_addr | output | 16 | Vector table address |
| push_psw | output | 1 | Push flag word strobe |
| push_pc | output | 1 | Push program counter strobe |
| save_ie | output | 1 | Enable bit to push |
| save_isp | output | 1 | Level bit to push |
| ie | output | 1 | Enable flag |
| isp | output | 1 | In-service level flag |
| nmi_busy | output | 1 | Non-maskable service active |

## Verification
The hardest state to reach is a break taken inside non-maskable service, followed by a break return, with a maskable and a second non-maskable request still latched. In that state the busy flag must outlive the break return. Only the later normal return may release the pending requests, and then only after a one-boundary hold. The directed sequence builds this state by nesting a break inside non-maskable service while requests stay parked. A long randomised run then mixes boundaries, off-boundary pulses, returns with random popped bits, and enable and disable strobes. A behavioural model compares every output on every clock.

// File: rtl/nic_pkg.sv
package nic_pkg;
  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_NMI  = 2'd1,
    K_MASK = 2'd2,
    K_BRK  = 2'd3
  } kind_e;

  localparam logic [15:0] VEC_NMI  = 16'h0002;
  localparam logic [15:0] VEC_BASE = 16'h0004;
  localparam logic [15:0] VEC_BRK  = 16'h003E;

  // vector address for a taken source
  function automatic logic [15:0] vec_of(kind_e k, int idx);
    case (k)
      K_NMI:   return VEC_NMI;
      K_MASK:  return VEC_BASE + 16'(2 * idx);
      K_BRK:   return VEC_BRK;
      default: return 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/nic_arb.sv
module nic_arb #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] eff,
  input  logic [N_SRC-1:0] lo,
  input  logic             ie,
  input  logic             isp,
  input  logic             blocked,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic             lvl
);
  logic [N_SRC-1:0] hi_set;
  logic [N_SRC-1:0] lo_set;
  logic             hi_any;
  logic [IDX_W-1:0] hi_idx;
  logic [IDX_W-1:0] lo_idx;

  assign hi_set = eff & ~lo;
  assign lo_set = eff & lo;
  assign hi_any = |hi_set;

  always_comb begin
    hi_idx = '0;
    lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_set[i]) hi_idx = IDX_W'(i);
      if (lo_set[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    lvl = 1'b0;
    if (ie && !blocked) begin
      if (hi_any) begin
        hit = 1'b1;
        idx = hi_idx;
      end else if (isp && |lo_set) begin
        hit = 1'b1;
        idx = lo_idx;
        lvl = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_flags.sv
module nic_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic bnd,
  input  logic take_any,
  input  logic take_mask,
  input  logic take_nmi,
  input  logic take_lvl,
  input  logic reti_stb,
  input  logic retb_stb,
  input  logic pop_ie,
  input  logic pop_isp,
  input  logic ei_stb,
  input  logic di_stb,
  output logic ie_q,
  output logic isp_q,
  output logic nmi_q,
  output logic hold_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      isp_q  <= 1'b1;
      nmi_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (bnd) begin
      hold_q <= 1'b0;
      if (take_any)  ie_q  <= 1'b0;
      if (take_mask) isp_q <= take_lvl;
      if (take_nmi)  nmi_q <= 1'b1;
    end else if (reti_stb || retb_stb) begin
      ie_q   <= pop_ie;
      isp_q  <= pop_isp;
      hold_q <= 1'b1;
      if (reti_stb) nmi_q <= 1'b0;
    end else if (ei_stb) begin
      ie_q <= 1'b1;
    end else if (di_stb) begin
      ie_q <= 1'b0;
    end
  end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             insn_bnd,
  input  logic             brk_req,
  input  logic             nmi_req,
  input  logic [N_SRC-1:0] irq_req,
  input  logic [N_SRC-1:0] irq_lo,
  input  logic             ei_stb,
  input  logic             di_stb,
  input  logic             reti_stb,
  input  logic             retb_stb,
  input  logic             pop_ie,
  input  logic             pop_isp,
  output logic             ack,
  output logic [1:0]       ack_kind,
  output logic [IDX_W-1:0] ack_idx,
  output logic [15:0]      vec_addr,
  output logic             push_psw,
  output logic             push_pc,
  output logic             save_ie,
  output logic             save_isp,
  output logic             ie,
  output logic             isp,
  output logic             nmi_busy
);
  import nic_pkg::*;

  logic [N_SRC-1:0] pend_q;
  logic             nmi_pend_q;
  logic [N_SRC-1:0] eff;
  logic             nmi_eff;
  logic             hold;
  logic             arb_hit;
  logic [IDX_W-1:0] arb_idx;
  logic             arb_lvl;
  logic             take_brk, take_nmi, take_mask, take_any;
  kind_e            take_kind;
  logic [N_SRC-1:0] clr_mask;

  assign eff     = pend_q | irq_req;
  assign nmi_eff = nmi_pend_q | nmi_req;

  nic_arb #(.N_SRC(N_SRC)) u_arb (
    .eff     (eff),
    .lo      (irq_lo),
    .ie      (ie),
    .isp     (isp),
    .blocked (nmi_busy | hold),
    .hit     (arb_hit),
    .idx     (arb_idx),
    .lvl     (arb_lvl)
  );

  assign take_brk  = insn_bnd & brk_req;
  assign take_nmi  = insn_bnd & ~brk_req & nmi_eff & ~nmi_busy;
  assign take_mask = insn_bnd & ~brk_req & ~(nmi_eff & ~nmi_busy) & arb_hit;
  assign take_any  = take_brk | take_nmi | take_mask;

  always_comb begin
    if (take_brk)       take_kind = K_BRK;
    else if (take_nmi)  take_kind = K_NMI;
    else if (take_mask) take_kind = K_MASK;
    else                take_kind = K_NONE;
  end

  always_comb begin
    clr_mask = '0;
    if (take_mask) clr_mask[arb_idx] = 1'b1;
  end

  nic_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .bnd       (insn_bnd),
    .take_any  (take_any),
    .take_mask (take_mask),
    .take_nmi  (take_nmi),
    .take_lvl  (arb_lvl),
    .reti_stb  (reti_stb),
    .retb_stb  (retb_stb),
    .pop_ie    (pop_ie),
    .pop_isp   (pop_isp),
    .ei_stb    (ei_stb),
    .di_stb    (di_stb),
    .ie_q      (ie),
    .isp_q     (isp),
    .nmi_q     (nmi_busy),
    .hold_q    (hold)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      nmi_pend_q <= 1'b0;
    end else if (insn_bnd) begin
      pend_q     <= eff & ~clr_mask;
      nmi_pend_q <= nmi_eff & ~take_nmi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack      <= 1'b0;
      ack_kind <= 2'd0;
      ack_idx  <= '0;
      vec_addr <= 16'h0000;
      push_psw <= 1'b0;
      push_pc  <= 1'b0;
      save_ie  <= 1'b0;
      save_isp <= 1'b0;
    end else begin
      ack      <= take_any;
      push_psw <= take_any;
      push_pc  <= push_psw;
      if (take_any) begin
        ack_kind <= take_kind;
        ack_idx  <= take_mask ? arb_idx : '0;
        vec_addr <= vec_of(take_kind, int'(arb_idx));
        save_ie  <= ie;
        save_isp <= isp;
      end
    end
  end
endmodule

// File: rtl/nest_irq_ctrl_chk.sv
module nest_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       insn_bnd,
  input logic       brk_req,
  input logic       retb_stb,
  input logic       ack,
  input logic [1:0] ack_kind,
  input logic       push_psw,
  input logic       push_pc,
  input logic       save_ie,
  input logic       save_isp,
  input logic       ie,
  input logic       isp,
  input logic       nmi_busy,
  input logic       hold
);
  assert_brk_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    insn_bnd && brk_req |=> ack && ack_kind == 2'd3);

  assert_entry_psw_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> push_psw && !ie);

  assert_entry_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_psw |=> push_pc);

  assert_mask_needs_ie_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_kind == 2'd2 |-> save_ie);

  assert_low_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_kind == 2'd2 && isp |-> save_isp);

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_kind != 2'd3 |-> !$past(nmi_busy));

  assert_retb_keeps_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retb_stb && !insn_bnd |=> $stable(nmi_busy));

  assert_return_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold && insn_bnd |=> !(ack && ack_kind == 2'd2));
endmodule

bind nest_irq_ctrl nest_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .insn_bnd (insn_bnd),
  .brk_req  (brk_req),
  .retb_stb (retb_stb),
  .ack      (ack),
  .ack_kind (ack_kind),
  .push_psw (push_psw),
  .push_pc  (push_pc),
  .save_ie  (save_ie),
  .save_isp (save_isp),
  .ie       (ie),
  .isp      (isp),
  .nmi_busy (nmi_busy),
  .hold     (hold)
);

// File: tb/nest_irq_ctrl_tb_top.sv
module nest_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_bnd = 0, brk_req = 0, nmi_req = 0;
  logic [N-1:0] irq_req = '0, irq_lo = '0;
  logic ei_stb = 0, di_stb = 0, reti_stb = 0, retb_stb = 0, pop_ie = 0, pop_isp = 0;
  logic ack, push_psw, push_pc, save_ie, save_isp, ie, isp, nmi_busy;
  logic [1:0] ack_kind;
  logic [IW-1:0] ack_idx;
  logic [15:0] vec_addr;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nest_irq_ctrl #(.N_SRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .brk_req(brk_req),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_lo(irq_lo),
    .ei_stb(ei_stb), .di_stb(di_stb), .reti_stb(reti_stb), .retb_stb(retb_stb),
    .pop_ie(pop_ie), .pop_isp(pop_isp), .ack(ack), .ack_kind(ack_kind),
    .ack_idx(ack_idx), .vec_addr(vec_addr), .push_psw(push_psw), .push_pc(push_pc),
    .save_ie(save_ie), .save_isp(save_isp), .ie(ie), .isp(isp), .nmi_busy(nmi_busy)
  );

  // reference model state
  int m_ie, m_isp, m_nmi, m_hold, m_npend;
  int m_pend[N];
  int e_ack, e_psw, e_pc, e_kind, e_idx, e_vec, e_sie, e_sisp;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_ie = 0; m_isp = 1; m_nmi = 0; m_hold = 0; m_npend = 0;
    foreach (m_pend[i]) m_pend[i] = 0;
    e_ack = 0; e_psw = 0; e_pc = 0; e_kind = 0; e_idx = 0; e_vec = 0; e_sie = 0; e_sisp = 0;
  endtask

  task automatic model_step();
    int got, gi, glvl;
    e_pc = e_psw;
    e_ack = 0;
    e_psw = 0;
    if (insn_bnd) begin
      got = 0; gi = 0; glvl = 0;
      for (int i = 0; i < N; i++) if (irq_req[i]) m_pend[i] = 1;
      if (nmi_req) m_npend = 1;
      if (brk_req) got = 3;
      else if (m_npend == 1 && m_nmi == 0) got = 1;
      else if (m_ie == 1 && m_nmi == 0 && m_hold == 0) begin
        for (int i = N - 1; i >= 0; i--)
          if (m_pend[i] == 1 && irq_lo[i] == 0) begin got = 2; gi = i; end
        if (got == 0 && m_isp == 1)
          for (int i = N - 1; i >= 0; i--)
            if (m_pend[i] == 1 && irq_lo[i] == 1) begin got = 2; gi = i; glvl = 1; end
      end
      if (got != 0) begin
        e_ack = 1; e_psw = 1; e_kind = got; e_sie = m_ie; e_sisp = m_isp;
        e_idx = (got == 2) ? gi : 0;
        e_vec = (got == 3) ? 62 : (got == 1) ? 2 : 4 + 2 * gi;
        m_ie = 0;
        if (got == 2) begin m_isp = glvl; m_pend[gi] = 0; end
        if (got == 1) begin m_nmi = 1; m_npend = 0; end
      end
      m_hold = 0;
    end else if (reti_stb || retb_stb) begin
      m_ie = pop_ie; m_isp = pop_isp; m_hold = 1;
      if (reti_stb) m_nmi = 0;
    end else if (ei_stb) m_ie = 1;
    else if (di_stb) m_ie = 0;
  endtask

  task automatic compare();
    chk(ack == e_ack, "R3 ack", ack, e_ack);
    chk(push_psw == e_psw, "R3 push_psw", push_psw, e_psw);
    chk(push_pc == e_pc, "R3 push_pc", push_pc, e_pc);
    chk(ie == m_ie, "R11 ie", ie, m_ie);
    chk(isp == m_isp, "R5 isp", isp, m_isp);
    chk(nmi_busy == m_nmi, "R7 nmi_busy", nmi_busy, m_nmi);
    if (e_ack == 1) begin
      chk(ack_kind == e_kind, "R6 kind", ack_kind, e_kind);
      chk(ack_idx == e_idx, "R6 idx", ack_idx, e_idx);
      chk(vec_addr == e_vec, "R12 vector", vec_addr, e_vec);
      chk(save_ie == e_sie, "R3 save_ie", save_ie, e_sie);
      chk(save_isp == e_sisp, "R3 save_isp", save_isp, e_sisp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    insn_bnd = 0; brk_req = 0; nmi_req = 0; irq_req = '0;
    ei_stb = 0; di_stb = 0; reti_stb = 0; retb_stb = 0;
  endtask

  task automatic bnd(input logic [N-1:0] r);
    insn_bnd = 1; irq_req = r; step();
  endtask

  task automatic ret(input bit is_b, input bit pie, input bit pisp);
    if (is_b) retb_stb = 1; else reti_stb = 1;
    pop_ie = pie; pop_isp = pisp; step();
  endtask

  task automatic want_ack(input int k, input int i, input string tag);
    chk(ack == 1 && ack_kind == k[1:0] && (k != 2 || ack_idx == i[IW-1:0]), tag,
        {ack, ack_kind, 1'b0, ack_idx}, (1 << 6) | (k << 4) | i);
  endtask

  task automatic want_none(input string tag);
    chk(ack == 0, tag, ack, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(ie == 0 && isp == 1 && nmi_busy == 0 && ack == 0 && push_psw == 0 && push_pc == 0,
        "R1 reset state", {ie, isp, nmi_busy, ack, push_psw, push_pc}, 6'b010000);

    // break with enable clear
    brk_req = 1; bnd('0);
    want_ack(3, 0, "R2 break with ie=0");
    chk(vec_addr == 16'h003E, "R2 break vector", vec_addr, 16'h003E);
    chk(push_psw == 1 && save_ie == 0, "R3 psw push first", push_psw, 1);
    step();
    chk(push_pc == 1 && push_psw == 0, "R3 pc push second", push_pc, 1);
    ret(1, 1, 1);
    chk(ie == 1 && isp == 1, "R8 break return restores", {ie, isp}, 3);
    bnd('0);

    // arbitration: lines 1(low), 3(high), 5(high)
    irq_lo = 8'b1101_0111;
    bnd(8'b0010_1010);
    want_ack(2, 3, "R6 high level lowest index wins");
    chk(vec_addr == 16'h000A, "R12 vector line 3", vec_addr, 16'h000A);
    chk(isp == 0, "R5 isp takes level", isp, 0);
    bnd('0);
    want_none("R4 pending refused with ie=0");
    ei_stb = 1; step();
    bnd('0);
    want_ack(2, 5, "R5 high level nests with isp=0");
    ei_stb = 1; step();
    bnd('0);
    want_none("R5 low level refused with isp=0");
    ret(0, 1, 0);
    bnd('0);
    want_none("R9 hold after return");
    bnd('0);
    want_none("R5 low level still refused");
    ret(0, 1, 1);
    bnd('0);
    want_none("R9 hold after final return");
    bnd('0);
    want_ack(2, 1, "R9 held request taken after one instruction");

    // off-boundary pulse ignored
    ret(0, 1, 1);
    bnd('0);
    irq_req = 8'b0000_0001; brk_req = 1; nmi_req = 1; step();
    bnd('0);
    want_none("R10 off-boundary pulses ignored");
    insn_bnd = 1; ei_stb = 0; di_stb = 1; step();
    chk(ie == 1, "R11 strobe ignored at boundary", ie, 1);

    // non-maskable nesting
    di_stb = 1; step();
    nmi_req = 1; bnd('0);
    want_ack(1, 0, "R7 nmi taken with ie=0");
    chk(vec_addr == 16'h0002 && nmi_busy == 1, "R7 nmi vector and busy", vec_addr, 2);
    ei_stb = 1; step();
    nmi_req = 1; bnd(8'b0000_1000);
    want_none("R7 busy blocks nmi and maskable");
    brk_req = 1; bnd('0);
    want_ack(3, 0, "R2 break inside nmi service");
    ret(1, 1, 1);
    chk(nmi_busy == 1, "R8 break return keeps busy", nmi_busy, 1);
    bnd('0);
    bnd('0);
    want_none("R7 still busy");
    ret(0, 1, 1);
    chk(nmi_busy == 0, "R8 normal return clears busy", nmi_busy, 0);
    bnd('0);
    want_ack(1, 0, "R7 pending nmi beats maskable");
    ret(0, 1, 1);
    bnd('0);
    want_none("R9 hold after nmi return");
    bnd('0);
    want_ack(2, 3, "R10 refused request stayed latched");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (n % 200 == 0) irq_lo = N'($urandom);
      if (r < 40) begin
        insn_bnd = 1;
        irq_req = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
        brk_req = ($urandom_range(0, 19) == 0);
        nmi_req = ($urandom_range(0, 29) == 0);
        ei_stb = ($urandom_range(0, 9) == 0);
      end else if (r < 50) begin
        if ($urandom_range(0, 2) == 0) retb_stb = 1; else reti_stb = 1;
        pop_ie = 1'($urandom); pop_isp = 1'($urandom);
      end else if (r < 70) begin
        ei_stb = 1;
      end else if (r < 75) begin
        di_stb = 1;
      end else if (r < 85) begin
        irq_req = N'($urandom); nmi_req = 1'($urandom);
      end
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule